// File: doc/BRIEF.md
# Configurable Memory-Mapped GPIO Controller

This block is a bank of general-purpose pins behind a small register file. A host reaches it through a single-cycle register port: an address, a write strobe, write data and read data. On the pin side it drives an output value and an output enable for each pin, and it samples each pin's input. The number of pins equals the register width, and that width is set by the `WIDTH` parameter.

Three elaboration-time choices shape the block. The output style is one of three:
- a plain data register,
- a pair of registers that set and clear individual bits when a 1 is written,
- a dedicated output register, with the input state read through the data address.

The direction style is one of three:
- no direction register, so every pin stays enabled,
- a register where a 1 means output,
- a register where a 1 means input.

A further switch reverses the mapping between register bits and pins. Only one direction style can be picked at a time. The enumerated parameter makes it impossible to select both register polarities at once.

The register offsets are fixed: data at 0, set at 1, clear at 2, direction at 3. Every other address in the 4-bit space is unmapped.

Top module: `gpio_mmio_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `pin_out` all zeros, `reg_rdata` zero, and every pin in its input state (`pin_oe` zero). The exception is the style without a direction register, where `pin_oe` is all ones.
- R2: In plain style, a write to offset 0 loads all of `pin_out` from the write data.
- R3: In set/clear style, a write to offset 1 drives high each pin whose write bit is 1 and leaves the others unchanged.
- R4: In set/clear style, a write to offset 2 drives low each pin whose write bit is 1 and leaves the others unchanged.
- R5: In dedicated-output style, a write to offset 1 loads the full output value (1 high, 0 low). In both non-plain styles, writes to offset 0 do not change `pin_out`.
- R6: A read of offset 0 returns the pin inputs after a two-flop synchronizer. A change on `pin_in` before clock edge k appears in `reg_rdata` after edge k+2.
- R7: With output-high direction style, a direction bit of 1 enables the pin's output (`pin_oe` 1). Reading offset 3 returns the stored direction bits.
- R8: With input-high direction style, a direction bit of 1 makes the pin an input (`pin_oe` 0). After reset, offset 3 reads all ones.
- R9: Without a direction register, `pin_oe` stays all ones. Offset 3 reads zero and writes to it have no effect.
- R10: With reversed numbering, pin n maps to register bit WIDTH-1-n in every register; otherwise pin n maps to bit n.
- R11: Offset 1 reads the output latch in set/clear and dedicated styles when `READ_OUT_LATCH` is 1, and reads zero otherwise. In plain style, writes to offset 1 have no effect.
- R12: Offset 2 always reads zero. Addresses 4 to 15 read zero, and writes to them change neither `pin_out` nor `pin_oe`.
- R13: `reg_rdata` is registered: it shows the register selected by `reg_addr` at the previous clock edge, in the state that register held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register offset |
| reg_wr | input | 1 | Write strobe, one access per cycle |
| reg_wdata | input | WIDTH | Write data in register bit order |
| reg_rdata | output | WIDTH | Registered read data |
| pin_out | output | WIDTH | Output value per pin |
| pin_oe | output | WIDTH | Output enable per pin, 1 = driving |
| pin_in | input | WIDTH | Raw pin inputs |

## Verification
The assertions check on every cycle:
- the set/clear bit updates, including that untouched pins hold their value;
- that data writes do not disturb a non-plain latch;
- the reset value of the latch;
- that the clear offset reads zero;
- that unmapped writes are inert;
- that a direction read matches the encoding of the enable outputs.

Only the bench scenarios show the rest:
- the two-edge input latency;
- the bit reversal across every register;
- the disabled set-register readback;
- how each style combination behaves against the cycle-by-cycle reference model.

// File: rtl/gpio_mmio_pkg.sv
package gpio_mmio_pkg;

  typedef enum logic [1:0] {
    OUT_PLAIN     = 2'd0,
    OUT_SETCLR    = 2'd1,
    OUT_DEDICATED = 2'd2
  } out_style_e;

  typedef enum logic [1:0] {
    DIR_FIXED   = 2'd0,
    DIR_OE_HIGH = 2'd1,
    DIR_IN_HIGH = 2'd2
  } dir_style_e;

  localparam int OFS_DATA = 0;
  localparam int OFS_SET  = 1;
  localparam int OFS_CLR  = 2;
  localparam int OFS_DIR  = 3;

  typedef struct packed {
    logic data;
    logic set;
    logic clr;
    logic dir;
  } reg_hit_t;

endpackage

// File: rtl/gpio_bit_order.sv
module gpio_bit_order #(
  parameter int WIDTH   = 32,
  parameter bit REVERSE = 1'b0
) (
  input  logic [WIDTH-1:0] src,
  output logic [WIDTH-1:0] dst
);
  // The mapping is its own inverse, so one instance serves writes and reads.
  if (REVERSE) begin : g_rev
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign dst[i] = src[WIDTH-1-i];
    end
  end else begin : g_fwd
    assign dst = src;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_mmio_pkg::*;
#(
  parameter int         WIDTH     = 32,
  parameter out_style_e OUT_STYLE = OUT_PLAIN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  reg_hit_t         hit,
  input  logic [WIDTH-1:0] wval,
  output logic [WIDTH-1:0] latch_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
    end else if (wr) begin
      case (OUT_STYLE)
        OUT_PLAIN: begin
          if (hit.data) latch_q <= wval;
        end
        OUT_SETCLR: begin
          if (hit.set)      latch_q <= latch_q | wval;
          else if (hit.clr) latch_q <= latch_q & ~wval;
        end
        OUT_DEDICATED: begin
          if (hit.set) latch_q <= wval;
        end
        default: latch_q <= latch_q;
      endcase
    end
  end
endmodule

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg
  import gpio_mmio_pkg::*;
#(
  parameter int         WIDTH     = 32,
  parameter dir_style_e DIR_STYLE = DIR_OE_HIGH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_dir,
  input  logic [WIDTH-1:0] wval,
  output logic [WIDTH-1:0] oe_q,
  output logic [WIDTH-1:0] dir_rb
);
  localparam logic [WIDTH-1:0] OE_RESET = (DIR_STYLE == DIR_FIXED) ? '1 : '0;

  // Enable is stored directly in pin polarity; the register encoding is
  // derived only on the read path.
  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q <= OE_RESET;
    end else begin
      case (DIR_STYLE)
        DIR_FIXED:   oe_q <= '1;
        DIR_OE_HIGH: if (wr_dir) oe_q <= wval;
        DIR_IN_HIGH: if (wr_dir) oe_q <= ~wval;
        default:     oe_q <= oe_q;
      endcase
    end
  end

  always_comb begin
    case (DIR_STYLE)
      DIR_OE_HIGH: dir_rb = oe_q;
      DIR_IN_HIGH: dir_rb = ~oe_q;
      default:     dir_rb = '0;
    endcase
  end
endmodule

// File: rtl/gpio_mmio_ctrl.sv
module gpio_mmio_ctrl
  import gpio_mmio_pkg::*;
#(
  parameter int         WIDTH          = 32,
  parameter int         ADDR_W         = 4,
  parameter int         SYNC_STAGES    = 2,
  parameter out_style_e OUT_STYLE      = OUT_PLAIN,
  parameter dir_style_e DIR_STYLE      = DIR_OE_HIGH,
  parameter bit         REVERSE_BITS   = 1'b0,
  parameter bit         READ_OUT_LATCH = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [WIDTH-1:0]  reg_wdata,
  output logic [WIDTH-1:0]  reg_rdata,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  input  logic [WIDTH-1:0]  pin_in
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
  localparam bit SET_READABLE = (OUT_STYLE != OUT_PLAIN) && READ_OUT_LATCH;

  reg_hit_t         hit;
  logic [WIDTH-1:0] wr_pin;
  logic [WIDTH-1:0] latch;
  logic [WIDTH-1:0] oe;
  logic [WIDTH-1:0] dir_rb;
  logic [WIDTH-1:0] in_sync;
  logic [WIDTH-1:0] rd_pin;
  logic [WIDTH-1:0] rd_bits;
  logic [WIDTH-1:0] rdata_q;

  assign hit.data = (reg_addr == A_DATA);
  assign hit.set  = (reg_addr == A_SET);
  assign hit.clr  = (reg_addr == A_CLR);
  assign hit.dir  = (reg_addr == A_DIR);

  gpio_bit_order #(.WIDTH(WIDTH), .REVERSE(REVERSE_BITS)) u_wr_order (
    .src (reg_wdata),
    .dst (wr_pin)
  );

  gpio_out_latch #(.WIDTH(WIDTH), .OUT_STYLE(OUT_STYLE)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .wr      (reg_wr),
    .hit     (hit),
    .wval    (wr_pin),
    .latch_q (latch)
  );

  gpio_dir_reg #(.WIDTH(WIDTH), .DIR_STYLE(DIR_STYLE)) u_dir (
    .clk    (clk),
    .rst    (rst),
    .wr_dir (reg_wr && hit.dir),
    .wval   (wr_pin),
    .oe_q   (oe),
    .dir_rb (dir_rb)
  );

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (in_sync)
  );

  always_comb begin
    case (reg_addr)
      A_DATA:  rd_pin = in_sync;
      A_SET:   rd_pin = SET_READABLE ? latch : '0;
      A_DIR:   rd_pin = dir_rb;
      default: rd_pin = '0;
    endcase
  end

  gpio_bit_order #(.WIDTH(WIDTH), .REVERSE(REVERSE_BITS)) u_rd_order (
    .src (rd_pin),
    .dst (rd_bits)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_bits;
  end

  assign reg_rdata = rdata_q;
  assign pin_out   = latch;
  assign pin_oe    = oe;
endmodule

// File: rtl/gpio_mmio_ctrl_chk.sv
module gpio_mmio_ctrl_chk
  import gpio_mmio_pkg::*;
#(
  parameter int         WIDTH        = 32,
  parameter int         ADDR_W       = 4,
  parameter out_style_e OUT_STYLE    = OUT_PLAIN,
  parameter dir_style_e DIR_STYLE    = DIR_OE_HIGH,
  parameter bit         REVERSE_BITS = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [WIDTH-1:0]  reg_wdata,
  input logic [WIDTH-1:0]  reg_rdata,
  input logic [WIDTH-1:0]  pin_out,
  input logic [WIDTH-1:0]  pin_oe
);
  function automatic logic [WIDTH-1:0] remap(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) r[i] = REVERSE_BITS ? v[WIDTH-1-i] : v[i];
    return r;
  endfunction

  function automatic logic [WIDTH-1:0] dir_enc(input logic [WIDTH-1:0] oe);
    return (DIR_STYLE == DIR_IN_HIGH) ? ~oe : oe;
  endfunction

  // R1
  rst_clears_out_chk: assert property (@(posedge clk)
    rst |=> (pin_out == '0));

  // R12
  unmapped_inert_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr > ADDR_W'(OFS_DIR)) |=> ($stable(pin_out) && $stable(pin_oe)));

  // R12
  clr_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == ADDR_W'(OFS_CLR)) |=> (reg_rdata == '0));

  if (OUT_STYLE == OUT_SETCLR) begin : g_setclr
    // R3
    set_drives_high_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && reg_addr == ADDR_W'(OFS_SET))
      |=> ((pin_out & $past(remap(reg_wdata))) == $past(remap(reg_wdata))));
    // R4
    clr_drives_low_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && reg_addr == ADDR_W'(OFS_CLR))
      |=> ((pin_out & $past(remap(reg_wdata))) == '0));
    // R3
    setclr_keeps_rest_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && (reg_addr == ADDR_W'(OFS_SET) || reg_addr == ADDR_W'(OFS_CLR)))
      |=> (((pin_out ^ $past(pin_out)) & ~$past(remap(reg_wdata))) == '0));
  end

  if (OUT_STYLE != OUT_PLAIN) begin : g_nonplain
    // R5
    data_write_inert_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && reg_addr == ADDR_W'(OFS_DATA)) |=> $stable(pin_out));
  end

  if (DIR_STYLE == DIR_FIXED) begin : g_fixed
    // R9
    fixed_oe_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && reg_addr == ADDR_W'(OFS_DIR)) |=> (pin_oe == '1));
  end else begin : g_dirreg
    // R7 and R8
    dir_readback_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_addr == ADDR_W'(OFS_DIR)) |=> (reg_rdata == remap(dir_enc($past(pin_oe)))));
  end
endmodule

bind gpio_mmio_ctrl gpio_mmio_ctrl_chk #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W), .OUT_STYLE(OUT_STYLE),
  .DIR_STYLE(DIR_STYLE), .REVERSE_BITS(REVERSE_BITS)
) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio_mmio_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_lane
  import gpio_mmio_pkg::*;
#(
  parameter int         W  = 8,
  parameter out_style_e OS = OUT_PLAIN,
  parameter dir_style_e DS = DIR_OE_HIGH,
  parameter bit         RV = 1'b0,
  parameter bit         RB = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  addr,
  input  logic        wr,
  input  logic [63:0] wdata,
  input  logic [63:0] pin_in,
  output logic [63:0] out_o,
  output logic [63:0] oe_o,
  output logic [63:0] rd_o,
  output int          n_chk,
  output int          n_bad
);
  logic [W-1:0] po, poe, prd;
  logic [W-1:0] m_out, m_oe, m_s1, m_s2, m_rd, wp, rp;
  logic [3:0]   last_addr;
  logic         started;

  gpio_mmio_ctrl #(.WIDTH(W), .OUT_STYLE(OS), .DIR_STYLE(DS),
                   .REVERSE_BITS(RV), .READ_OUT_LATCH(RB)) u_gpio_mmio_ctrl (
    .clk(clk), .rst(rst), .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata[W-1:0]),
    .reg_rdata(prd), .pin_out(po), .pin_oe(poe), .pin_in(pin_in[W-1:0])
  );

  assign out_o = 64'(po);
  assign oe_o  = 64'(poe);
  assign rd_o  = 64'(prd);

  function automatic int rbit(input int p);
    return RV ? W-1-p : p;
  endfunction

  initial begin
    n_chk = 0; n_bad = 0; started = 1'b0; last_addr = '0;
  end

  // Behavioural reference: state kept in pin order, R10 mapping applied at the edges.
  always @(posedge clk) begin
    for (int p = 0; p < W; p++) wp[p] = wdata[rbit(p)];
    if (rst) begin
      m_out = '0;
      m_oe  = (DS == DIR_FIXED) ? '1 : '0;
      m_s1  = '0; m_s2 = '0; m_rd = '0;
    end else begin
      case (addr)
        4'd0:    rp = m_s2;
        4'd1:    rp = (OS != OUT_PLAIN && RB) ? m_out : '0;
        4'd3:    rp = (DS == DIR_FIXED) ? '0 : (DS == DIR_OE_HIGH) ? m_oe : ~m_oe;
        default: rp = '0;
      endcase
      for (int p = 0; p < W; p++) m_rd[rbit(p)] = rp[p];
      if (wr) begin
        if (addr == 4'd0 && OS == OUT_PLAIN) m_out = wp;
        if (addr == 4'd1 && OS == OUT_SETCLR) m_out = m_out | wp;
        if (addr == 4'd1 && OS == OUT_DEDICATED) m_out = wp;
        if (addr == 4'd2 && OS == OUT_SETCLR) m_out = m_out & ~wp;
        if (addr == 4'd3 && DS == DIR_OE_HIGH) m_oe = wp;
        if (addr == 4'd3 && DS == DIR_IN_HIGH) m_oe = ~wp;
      end
      m_s2 = m_s1;
      m_s1 = pin_in[W-1:0];
    end
    last_addr = addr;
    started = 1'b1;
  end

  always @(negedge clk) begin
    string otag, dtag, rtag;
    if (started) begin
      otag = (OS == OUT_PLAIN) ? "R2" : (OS == OUT_SETCLR) ? "R3" : "R5";
      dtag = (DS == DIR_FIXED) ? "R9" : (DS == DIR_OE_HIGH) ? "R7" : "R8";
      case (last_addr)
        4'd0:    rtag = "R6";
        4'd1:    rtag = "R11";
        4'd3:    rtag = dtag;
        default: rtag = "R12";
      endcase
      n_chk += 3;
      if (po !== m_out) begin
        n_bad++; $display("FAIL %s pin_out act=%h exp=%h", otag, po, m_out);
      end
      if (poe !== m_oe) begin
        n_bad++; $display("FAIL %s pin_oe act=%h exp=%h", dtag, poe, m_oe);
      end
      if (prd !== m_rd) begin
        n_bad++; $display("FAIL %s R13 rdata act=%h exp=%h", rtag, prd, m_rd);
      end
    end
  end
endmodule

module gpio_mmio_ctrl_bench;
  import gpio_mmio_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] pin_in = '0;
  int          n_chk = 0, n_bad = 0;

  logic [63:0] a_out, a_oe, a_rd, b_out, b_oe, b_rd, c_out, c_oe, c_rd, d_out, d_oe, d_rd;
  int          a_c, a_b, b_c, b_b, c_c, c_b, d_c, d_b;

  always #2.5 clk = ~clk;

  gpio_lane #(.W(8),  .OS(OUT_PLAIN),     .DS(DIR_OE_HIGH), .RV(1'b0), .RB(1'b1)) lane_a (
    .clk, .rst, .addr, .wr, .wdata, .pin_in, .out_o(a_out), .oe_o(a_oe), .rd_o(a_rd), .n_chk(a_c), .n_bad(a_b));
  gpio_lane #(.W(16), .OS(OUT_SETCLR),    .DS(DIR_IN_HIGH), .RV(1'b1), .RB(1'b1)) lane_b (
    .clk, .rst, .addr, .wr, .wdata, .pin_in, .out_o(b_out), .oe_o(b_oe), .rd_o(b_rd), .n_chk(b_c), .n_bad(b_b));
  gpio_lane #(.W(8),  .OS(OUT_DEDICATED), .DS(DIR_FIXED),   .RV(1'b0), .RB(1'b1)) lane_c (
    .clk, .rst, .addr, .wr, .wdata, .pin_in, .out_o(c_out), .oe_o(c_oe), .rd_o(c_rd), .n_chk(c_c), .n_bad(c_b));
  gpio_lane #(.W(8),  .OS(OUT_DEDICATED), .DS(DIR_OE_HIGH), .RV(1'b1), .RB(1'b0)) lane_d (
    .clk, .rst, .addr, .wr, .wdata, .pin_in, .out_o(d_out), .oe_o(d_oe), .rd_o(d_rd), .n_chk(d_c), .n_bad(d_b));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk + a_c + b_c + c_c + d_c,
             n_bad + a_b + b_b + c_b + d_b);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) step();
    // R1 reset state
    chk("R1 a out", a_out, 64'h0);
    chk("R1 a oe", a_oe, 64'h0);
    chk("R1 b oe", b_oe, 64'h0);
    chk("R1 R9 c oe", c_oe, 64'hFF);
    chk("R1 a rd", a_rd, 64'h0);
    rst = 1'b0;
    addr = 4'd3; step();
    chk("R8 b dir after reset", b_rd, 64'hFFFF);
    chk("R7 a dir after reset", a_rd, 64'h0);
    chk("R9 c dir reads zero", c_rd, 64'h0);
    addr = 4'd1; wr = 1'b1; wdata = 64'h1; step(); wr = 1'b0;
    chk("R10 R3 b set bit0 -> pin15", b_out, 64'h8000);
    chk("R5 c dedicated load", c_out, 64'h01);
    chk("R10 d reversed load", d_out, 64'h80);
    chk("R11 a plain set write ignored", a_out, 64'h0);
    step();
    chk("R11 b set readback", b_rd, 64'h1);
    chk("R11 d readback disabled", d_rd, 64'h0);
    chk("R11 c set readback", c_rd, 64'h1);
    addr = 4'd2; wr = 1'b1; wdata = 64'h1; step(); wr = 1'b0;
    chk("R4 b clr", b_out, 64'h0);
    chk("R12 c clr write no effect", c_out, 64'h01);
    step();
    chk("R12 b clr reads zero", b_rd, 64'h0);
    addr = 4'd9; wr = 1'b1; wdata = '1; step(); wr = 1'b0;
    chk("R12 a unmapped write", a_out, 64'h0);
    chk("R12 c unmapped write", c_out, 64'h01);
    chk("R12 a oe unmapped write", a_oe, 64'h0);
    step();
    chk("R12 unmapped read", a_rd, 64'h0);
    addr = 4'd0; wr = 1'b1; wdata = 64'hA5; step(); wr = 1'b0;
    chk("R2 a data write", a_out, 64'hA5);
    chk("R5 c data write ignored", c_out, 64'h01);
    addr = 4'd3; wr = 1'b1; wdata = 64'h0F; step(); wr = 1'b0;
    chk("R7 a oe", a_oe, 64'h0F);
    chk("R8 R10 b oe", b_oe, 64'h0FFF);
    chk("R9 c oe fixed", c_oe, 64'hFF);
    addr = 4'd0; step();
    pin_in = 64'h3C;
    step();
    chk("R6 not visible after 1 edge", a_rd, 64'h0);
    step();
    chk("R6 not visible after 2 edges", a_rd, 64'h0);
    step();
    chk("R6 visible after 3 edges", a_rd, 64'h3C);
    addr = 4'd3; step();
    chk("R13 rdata follows previous address", a_rd, 64'h0F);
    for (int i = 0; i < 4000; i++) begin
      rst    = ($urandom % 300) == 0;
      addr   = 4'($urandom % 8);
      wr     = $urandom % 2;
      wdata  = {$urandom, $urandom};
      pin_in = ($urandom % 4 == 0) ? {$urandom, $urandom} : pin_in;
      step();
    end
    rst = 1'b0; wr = 1'b0;
    step();
    finish_run();
  end
endmodule